// File: doc/BRIEF.md
# Streaming Matrix Product Engine

This block forms the integer product C = A × B. A and B sit in two external block RAMs with one-cycle read latency. C goes into a third RAM through a write port. Each source matrix is described by a descriptor with these fields:

- a valid flag
- a base address
- a row pitch (stride)
- a row count
- a column count

Element (r, c) of a source lives at base + r·stride + c. The engine walks the index space in a fixed order: output row, then output column, then the inner index. It issues one read to each source RAM on every clock. The two returned words then pass through a multiply stage and an accumulate stage. Tag registers carry the target C index alongside the data so that it stays aligned.

The accumulator keeps adding products as long as the target C index stays the same. When the index changes, it writes the finished sum out. The final sum is written one cycle after the last product arrives. C is packed row-major from address 0. The engine drives an output descriptor for C (base, pitch, rows, columns and a valid flag). The flag rises after the last write and stays set until the next run is accepted.

Top module: `matmul_stream`

## Requirements
- R1: A run is accepted on a clock edge where no run is in progress, both descriptor valid flags are high, the column count of A equals the row count of B, and all three dimensions (A rows, A columns, B columns) are non-zero.
- R2: Descriptors that fail the R1 conditions (mismatched inner size or a zero dimension) start nothing: no read, no write, and the C valid flag keeps its previous value.
- R3: Element (r, c) of A is read from a_base + r·a_stride + c, and element (r, c) of B from b_base + r·b_stride + c, with addresses wrapping modulo the address width.
- R4: C element (i, j) is written at address i·N + j, where N is the column count of B. From the accepted edge on, the C descriptor reports base 0, stride N, rows M (rows of A) and columns N.
- R5: Each C element equals the sum over k of A(i,k)·B(k,j), with 16-bit two's-complement inputs and a 32-bit two's-complement result that wraps on overflow.
- R6: The C valid flag is cleared on the accepted edge and rises exactly M·N·K + 4 clock edges later, where K is the inner size. It then stays high until the next accepted run.
- R7: A run makes exactly M·N writes to C, each C address exactly once, and none while the C valid flag is high.
- R8: While a run is in progress, descriptor inputs are ignored: a new valid descriptor neither restarts nor alters the run.
- R9: A run issues exactly M·N·K read strobes to each source RAM, one per clock, on consecutive cycles. No reads occur while the C valid flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_desc_valid | input | 1 | A descriptor valid |
| a_desc_base | input | AW | A base address |
| a_desc_stride | input | AW | A row pitch |
| a_desc_rows | input | DIM_W | A rows (M) |
| a_desc_cols | input | DIM_W | A columns (K) |
| b_desc_valid | input | 1 | B descriptor valid |
| b_desc_base | input | AW | B base address |
| b_desc_stride | input | AW | B row pitch |
| b_desc_rows | input | DIM_W | B rows (must equal K) |
| b_desc_cols | input | DIM_W | B columns (N) |
| a_rd_en | output | 1 | Read strobe to RAM A |
| a_rd_addr | output | AW | Read address to RAM A |
| a_rd_data | input | DW | Data from RAM A, one cycle after the strobe |
| b_rd_en | output | 1 | Read strobe to RAM B |
| b_rd_addr | output | AW | Read address to RAM B |
| b_rd_data | input | DW | Data from RAM B, one cycle after the strobe |
| c_wr_en | output | 1 | Write strobe to RAM C |
| c_wr_addr | output | AW | Write address to RAM C |
| c_wr_data | output | ACC_W | Write data to RAM C |
| c_desc_valid | output | 1 | C result complete |
| c_desc_base | output | AW | C base address (always 0) |
| c_desc_stride | output | AW | C row pitch (N) |
| c_desc_rows | output | DIM_W | C rows (M) |
| c_desc_cols | output | DIM_W | C columns (N) |

## Verification
A tag that slips against its data shows up in two ways. Sums come out split across neighbouring C cells, or C gets more or fewer than M·N writes. The write log reveals this before the valid flag rises. An address walk that goes wrong writes wrong values, and every cell of C is compared against a product formed independently from the RAM images. A control state that is stuck or leaks shows up in the cycle count to the valid flag, which must be exact. It also shows up as strobes appearing while the flag is high, or as a run that starts from a bad or ignored descriptor.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    RUN_IDLE,
    RUN_BUSY,
    RUN_DONE
  } run_state_t;

  // cycles between a read strobe and its data at the RAM port
  localparam int RD_LAT = 1;
endpackage

// File: rtl/mm_addr_gen.sv
module mm_addr_gen #(
  parameter int AW    = 10,
  parameter int DIM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    a_base,
  input  logic [AW-1:0]    a_stride,
  input  logic [AW-1:0]    b_base,
  input  logic [AW-1:0]    b_stride,
  input  logic [DIM_W-1:0] m_len,
  input  logic [DIM_W-1:0] n_len,
  input  logic [DIM_W-1:0] k_len,
  output logic             rd_en,
  output logic [AW-1:0]    a_addr,
  output logic [AW-1:0]    b_addr,
  output logic [AW-1:0]    tag,
  output logic             last
);
  localparam logic [DIM_W-1:0] ONE_D = DIM_W'(1);
  localparam logic [AW-1:0]    ONE_A = AW'(1);

  logic [DIM_W-1:0] k_cnt, j_cnt, i_cnt;
  logic [DIM_W-1:0] m_q, n_q, k_q;
  logic [AW-1:0]    a_stride_q, b_stride_q, b_base_q;
  logic [AW-1:0]    a_row, b_col;

  logic             k_end, j_end, nxt_last;
  logic [DIM_W-1:0] nxt_k, nxt_j, nxt_i;

  always_comb begin
    k_end    = (k_cnt == k_q - ONE_D);
    j_end    = (j_cnt == n_q - ONE_D);
    nxt_k    = k_end ? '0 : k_cnt + ONE_D;
    nxt_j    = k_end ? (j_end ? '0 : j_cnt + ONE_D) : j_cnt;
    nxt_i    = (k_end && j_end) ? i_cnt + ONE_D : i_cnt;
    nxt_last = (nxt_k == k_q - ONE_D) && (nxt_j == n_q - ONE_D) &&
               (nxt_i == m_q - ONE_D);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en      <= 1'b0;
      last       <= 1'b0;
      a_addr     <= '0;
      b_addr     <= '0;
      tag        <= '0;
      k_cnt      <= '0;
      j_cnt      <= '0;
      i_cnt      <= '0;
      m_q        <= '0;
      n_q        <= '0;
      k_q        <= '0;
      a_stride_q <= '0;
      b_stride_q <= '0;
      b_base_q   <= '0;
      a_row      <= '0;
      b_col      <= '0;
    end else if (start) begin
      m_q        <= m_len;
      n_q        <= n_len;
      k_q        <= k_len;
      a_stride_q <= a_stride;
      b_stride_q <= b_stride;
      b_base_q   <= b_base;
      a_row      <= a_base;
      b_col      <= b_base;
      a_addr     <= a_base;
      b_addr     <= b_base;
      tag        <= '0;
      k_cnt      <= '0;
      j_cnt      <= '0;
      i_cnt      <= '0;
      rd_en      <= 1'b1;
      last       <= (m_len == ONE_D) && (n_len == ONE_D) && (k_len == ONE_D);
    end else if (rd_en) begin
      if (last) begin
        rd_en <= 1'b0;
        last  <= 1'b0;
      end else begin
        k_cnt <= nxt_k;
        j_cnt <= nxt_j;
        i_cnt <= nxt_i;
        last  <= nxt_last;
        if (!k_end) begin
          a_addr <= a_addr + ONE_A;
          b_addr <= b_addr + b_stride_q;
        end else begin
          tag <= tag + ONE_A;
          if (!j_end) begin
            a_addr <= a_row;
            b_col  <= b_col + ONE_A;
            b_addr <= b_col + ONE_A;
          end else begin
            b_col  <= b_base_q;
            b_addr <= b_base_q;
            a_row  <= a_row + a_stride_q;
            a_addr <= a_row + a_stride_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mm_mul_stage.sv
module mm_mul_stage #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_v,
  input  logic [AW-1:0]          in_tag,
  input  logic                   in_last,
  input  logic signed [DW-1:0]   in_a,
  input  logic signed [DW-1:0]   in_b,
  output logic                   out_v,
  output logic [AW-1:0]          out_tag,
  output logic                   out_last,
  output logic signed [2*DW-1:0] out_prod
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_last <= 1'b0;
      out_tag  <= '0;
      out_prod <= '0;
    end else begin
      out_v    <= in_v;
      out_last <= in_v && in_last;
      out_tag  <= in_tag;
      out_prod <= in_a * in_b;
    end
  end
endmodule

// File: rtl/mm_acc_stage.sv
module mm_acc_stage #(
  parameter int AW    = 10,
  parameter int PW    = 32,
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic [AW-1:0]        in_tag,
  input  logic                 in_last,
  input  logic signed [PW-1:0] in_prod,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [ACC_W-1:0]     wr_data,
  output logic                 wr_final
);
  logic                    have;
  logic                    flush;
  logic [AW-1:0]           held_tag;
  logic signed [ACC_W-1:0] held_sum;
  logic signed [ACC_W-1:0] prod_ext;

  assign prod_ext = ACC_W'(in_prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      have     <= 1'b0;
      flush    <= 1'b0;
      held_tag <= '0;
      held_sum <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_final <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      wr_final <= 1'b0;
      flush    <= in_v && in_last;
      if (in_v) begin
        if (have && (in_tag != held_tag)) begin
          wr_en    <= 1'b1;
          wr_addr  <= held_tag;
          wr_data  <= held_sum;
          held_sum <= prod_ext;
        end else if (have) begin
          held_sum <= held_sum + prod_ext;
        end else begin
          held_sum <= prod_ext;
        end
        held_tag <= in_tag;
        have     <= 1'b1;
      end else if (flush) begin
        wr_en    <= 1'b1;
        wr_addr  <= held_tag;
        wr_data  <= held_sum;
        wr_final <= 1'b1;
        have     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/matmul_stream.sv
module matmul_stream #(
  parameter int DW    = 16,
  parameter int AW    = 10,
  parameter int DIM_W = 6,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_desc_valid,
  input  logic [AW-1:0]    a_desc_base,
  input  logic [AW-1:0]    a_desc_stride,
  input  logic [DIM_W-1:0] a_desc_rows,
  input  logic [DIM_W-1:0] a_desc_cols,
  input  logic             b_desc_valid,
  input  logic [AW-1:0]    b_desc_base,
  input  logic [AW-1:0]    b_desc_stride,
  input  logic [DIM_W-1:0] b_desc_rows,
  input  logic [DIM_W-1:0] b_desc_cols,
  output logic             a_rd_en,
  output logic [AW-1:0]    a_rd_addr,
  input  logic [DW-1:0]    a_rd_data,
  output logic             b_rd_en,
  output logic [AW-1:0]    b_rd_addr,
  input  logic [DW-1:0]    b_rd_data,
  output logic             c_wr_en,
  output logic [AW-1:0]    c_wr_addr,
  output logic [ACC_W-1:0] c_wr_data,
  output logic             c_desc_valid,
  output logic [AW-1:0]    c_desc_base,
  output logic [AW-1:0]    c_desc_stride,
  output logic [DIM_W-1:0] c_desc_rows,
  output logic [DIM_W-1:0] c_desc_cols
);
  import mm_pkg::*;

  localparam int PW = 2 * DW;

  run_state_t st;
  logic       go;
  logic       gen_rd, gen_last;
  logic [AW-1:0] gen_tag;

  logic          dl_v    [RD_LAT+1];
  logic          dl_last [RD_LAT+1];
  logic [AW-1:0] dl_tag  [RD_LAT+1];

  logic          mul_v, mul_last;
  logic [AW-1:0] mul_tag;
  logic signed [PW-1:0] mul_prod;
  logic          acc_final;

  assign go = (st != RUN_BUSY) && a_desc_valid && b_desc_valid &&
              (a_desc_cols == b_desc_rows) && (a_desc_rows != '0) &&
              (a_desc_cols != '0) && (b_desc_cols != '0);

  mm_addr_gen #(.AW(AW), .DIM_W(DIM_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .start    (go),
    .a_base   (a_desc_base),
    .a_stride (a_desc_stride),
    .b_base   (b_desc_base),
    .b_stride (b_desc_stride),
    .m_len    (a_desc_rows),
    .n_len    (b_desc_cols),
    .k_len    (a_desc_cols),
    .rd_en    (gen_rd),
    .a_addr   (a_rd_addr),
    .b_addr   (b_rd_addr),
    .tag      (gen_tag),
    .last     (gen_last)
  );

  assign a_rd_en = gen_rd;
  assign b_rd_en = gen_rd;

  assign dl_v[0]    = gen_rd;
  assign dl_last[0] = gen_last;
  assign dl_tag[0]  = gen_tag;

  // tag line matching the RAM read latency
  for (genvar g = 0; g < RD_LAT; g++) begin : g_rd_align
    always_ff @(posedge clk) begin
      if (rst) begin
        dl_v[g+1]    <= 1'b0;
        dl_last[g+1] <= 1'b0;
        dl_tag[g+1]  <= '0;
      end else begin
        dl_v[g+1]    <= dl_v[g];
        dl_last[g+1] <= dl_last[g];
        dl_tag[g+1]  <= dl_tag[g];
      end
    end
  end

  mm_mul_stage #(.DW(DW), .AW(AW)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .in_v     (dl_v[RD_LAT]),
    .in_tag   (dl_tag[RD_LAT]),
    .in_last  (dl_last[RD_LAT]),
    .in_a     ($signed(a_rd_data)),
    .in_b     ($signed(b_rd_data)),
    .out_v    (mul_v),
    .out_tag  (mul_tag),
    .out_last (mul_last),
    .out_prod (mul_prod)
  );

  mm_acc_stage #(.AW(AW), .PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .in_v     (mul_v),
    .in_tag   (mul_tag),
    .in_last  (mul_last),
    .in_prod  (mul_prod),
    .wr_en    (c_wr_en),
    .wr_addr  (c_wr_addr),
    .wr_data  (c_wr_data),
    .wr_final (acc_final)
  );

  assign c_desc_base = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= RUN_IDLE;
      c_desc_valid  <= 1'b0;
      c_desc_rows   <= '0;
      c_desc_cols   <= '0;
      c_desc_stride <= '0;
    end else if (go) begin
      st            <= RUN_BUSY;
      c_desc_valid  <= 1'b0;
      c_desc_rows   <= a_desc_rows;
      c_desc_cols   <= b_desc_cols;
      c_desc_stride <= AW'(b_desc_cols);
    end else if ((st == RUN_BUSY) && c_wr_en && acc_final) begin
      st           <= RUN_DONE;
      c_desc_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/matmul_stream_chk.sv
module matmul_stream_chk #(
  parameter int AW    = 10,
  parameter int DIM_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             a_desc_valid,
  input logic             b_desc_valid,
  input logic [DIM_W-1:0] a_desc_cols,
  input logic [DIM_W-1:0] b_desc_rows,
  input logic             a_rd_en,
  input logic             b_rd_en,
  input logic             c_wr_en,
  input logic [AW-1:0]    c_wr_addr,
  input logic             c_desc_valid,
  input logic [DIM_W-1:0] c_desc_rows,
  input logic [DIM_W-1:0] c_desc_cols
);
  // R7
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    c_wr_en |-> (int'(c_wr_addr) < int'(c_desc_rows) * int'(c_desc_cols)));

  // R7
  no_write_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    c_desc_valid |-> !c_wr_en);

  // R6
  valid_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(c_desc_valid) |-> $past(c_wr_en));

  // R9
  no_read_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    c_desc_valid |-> (!a_rd_en && !b_rd_en));

  // R1
  start_needs_desc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(a_rd_en) |-> $past(a_desc_valid && b_desc_valid &&
                             (a_desc_cols == b_desc_rows)));
endmodule

bind matmul_stream matmul_stream_chk #(.AW(AW), .DIM_W(DIM_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .a_desc_valid (a_desc_valid),
  .b_desc_valid (b_desc_valid),
  .a_desc_cols  (a_desc_cols),
  .b_desc_rows  (b_desc_rows),
  .a_rd_en      (a_rd_en),
  .b_rd_en      (b_rd_en),
  .c_wr_en      (c_wr_en),
  .c_wr_addr    (c_wr_addr),
  .c_desc_valid (c_desc_valid),
  .c_desc_rows  (c_desc_rows),
  .c_desc_cols  (c_desc_cols)
);

// File: tb/matmul_stream_bench.sv
module matmul_stream_bench;
  localparam int DW = 16, AW = 10, DIM_W = 6, ACC_W = 32;
  localparam int DEPTH = 1 << AW;
  localparam int NCASE = 6;
  // M, N, K, a_base, a_stride, b_base, b_stride
  localparam int CASES [NCASE][7] = '{
    '{2, 2, 2,   0, 2,   0, 2},
    '{3, 4, 5,  10, 7, 100, 6},
    '{1, 1, 1,   5, 1,   9, 1},
    '{4, 3, 1,   0, 3,  50, 3},
    '{5, 1, 6, 200, 9, 300, 1},
    '{1, 6, 3, 400, 3, 500, 8}
  };

  logic clk = 0;
  logic rst = 1;
  always #2 clk = ~clk;

  logic             a_desc_valid = 0, b_desc_valid = 0;
  logic [AW-1:0]    a_desc_base = 0, a_desc_stride = 0, b_desc_base = 0, b_desc_stride = 0;
  logic [DIM_W-1:0] a_desc_rows = 0, a_desc_cols = 0, b_desc_rows = 0, b_desc_cols = 0;
  logic             a_rd_en, b_rd_en, c_wr_en, c_desc_valid;
  logic [AW-1:0]    a_rd_addr, b_rd_addr, c_wr_addr, c_desc_base, c_desc_stride;
  logic [DW-1:0]    a_rd_data, b_rd_data;
  logic [ACC_W-1:0] c_wr_data;
  logic [DIM_W-1:0] c_desc_rows, c_desc_cols;

  matmul_stream #(.DW(DW), .AW(AW), .DIM_W(DIM_W), .ACC_W(ACC_W)) u_matmul_stream (
    .clk(clk), .rst(rst),
    .a_desc_valid(a_desc_valid), .a_desc_base(a_desc_base), .a_desc_stride(a_desc_stride),
    .a_desc_rows(a_desc_rows), .a_desc_cols(a_desc_cols),
    .b_desc_valid(b_desc_valid), .b_desc_base(b_desc_base), .b_desc_stride(b_desc_stride),
    .b_desc_rows(b_desc_rows), .b_desc_cols(b_desc_cols),
    .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
    .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
    .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data),
    .c_desc_valid(c_desc_valid), .c_desc_base(c_desc_base), .c_desc_stride(c_desc_stride),
    .c_desc_rows(c_desc_rows), .c_desc_cols(c_desc_cols)
  );

  logic signed [DW-1:0] mem_a [DEPTH];
  logic signed [DW-1:0] mem_b [DEPTH];
  logic [ACC_W-1:0]     mem_c [DEPTH];
  int                   hits  [DEPTH];
  int wr_cnt = 0, rda_cnt = 0, rdb_cnt = 0;
  int checks = 0, fails = 0;
  int cyc = 0;

  always @(posedge clk) begin
    a_rd_data <= mem_a[a_rd_addr];
    b_rd_data <= mem_b[b_rd_addr];
    if (a_rd_en) rda_cnt++;
    if (b_rd_en) rdb_cnt++;
    if (c_wr_en) begin
      mem_c[c_wr_addr] <= c_wr_data;
      hits[c_wr_addr]++;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_cnt = 0; rda_cnt = 0; rdb_cnt = 0;
    for (int x = 0; x < DEPTH; x++) begin
      hits[x] = 0;
      mem_c[x] = '0;
    end
  endtask

  task automatic set_desc(input int m, input int n, input int k, input int kb,
                          input int ab, input int as, input int bb, input int bs);
    a_desc_rows = DIM_W'(m); a_desc_cols = DIM_W'(k);
    b_desc_rows = DIM_W'(kb); b_desc_cols = DIM_W'(n);
    a_desc_base = AW'(ab); a_desc_stride = AW'(as);
    b_desc_base = AW'(bb); b_desc_stride = AW'(bs);
  endtask

  // run one product; inject = pulse another descriptor mid-run
  task automatic run_case(input int m, input int n, input int k, input int ab,
                          input int as, input int bb, input int bs, input bit inject);
    int cnt;
    int exp;
    @(negedge clk);
    clear_logs();
    set_desc(m, n, k, k, ab, as, bb, bs);
    a_desc_valid = 1; b_desc_valid = 1;
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt == 0) begin a_desc_valid = 0; b_desc_valid = 0; end
      if (inject && cnt == 3) begin
        set_desc(1, 1, 1, 1, 7, 1, 8, 1);
        a_desc_valid = 1; b_desc_valid = 1;
      end
      if (inject && cnt == 4) begin a_desc_valid = 0; b_desc_valid = 0; end
      if (c_desc_valid || cnt > 5000) break;
      @(posedge clk);
      cnt++;
    end
    // R6 exact latency
    chk(cnt == m*n*k + 4, inject ? "R8 latency" : "R6 latency", cnt, m*n*k + 4);
    // R4 descriptor
    chk(c_desc_rows == DIM_W'(m) && c_desc_cols == DIM_W'(n) &&
        c_desc_stride == AW'(n) && c_desc_base == '0, "R4 c descriptor",
        c_desc_cols, n);
    // R7 write count and uniqueness
    chk(wr_cnt == m*n, "R7 write count", wr_cnt, m*n);
    for (int x = 0; x < m*n; x++)
      if (hits[x] != 1) chk(0, "R7 address written once", hits[x], 1);
    // R9 read strobes
    chk(rda_cnt == m*n*k && rdb_cnt == m*n*k, "R9 read count", rda_cnt, m*n*k);
    // R3 R5 values
    for (int i = 0; i < m; i++)
      for (int j = 0; j < n; j++) begin
        exp = 0;
        for (int kk = 0; kk < k; kk++)
          exp += int'(mem_a[(ab + i*as + kk) % DEPTH]) * int'(mem_b[(bb + kk*bs + j) % DEPTH]);
        chk(mem_c[i*n + j] == ACC_W'(exp), inject ? "R8 value" : "R3 R5 value",
            int'(mem_c[i*n + j]), exp);
      end
  endtask

  task automatic bad_start(input int m, input int n, input int k, input int kb, input string req);
    logic prev_valid;
    @(negedge clk);
    clear_logs();
    prev_valid = c_desc_valid;
    set_desc(m, n, k, kb, 0, 4, 0, 4);
    a_desc_valid = 1; b_desc_valid = 1;
    @(negedge clk);
    a_desc_valid = 0; b_desc_valid = 0;
    repeat (20) @(negedge clk);
    chk(rda_cnt == 0 && wr_cnt == 0, req, rda_cnt + wr_cnt, 0);
    chk(c_desc_valid == prev_valid, req, c_desc_valid, prev_valid);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int x = 0; x < DEPTH; x++) begin
      mem_a[x] = DW'(x*1237 + 345);
      mem_b[x] = DW'(x*2897 + 77);
      mem_c[x] = '0;
      hits[x] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk(!c_desc_valid && !c_wr_en && !a_rd_en && !b_rd_en, "R6 reset state",
        {c_desc_valid, c_wr_en, a_rd_en}, 0);

    // R2 before any run: valid stays low
    bad_start(2, 2, 3, 2, "R2 inner mismatch");

    for (int t = 0; t < NCASE; t++)
      run_case(CASES[t][0], CASES[t][1], CASES[t][2], CASES[t][3],
               CASES[t][4], CASES[t][5], CASES[t][6], 1'b0);

    // R6 hold after completion
    repeat (10) @(negedge clk);
    chk(c_desc_valid, "R6 valid held", c_desc_valid, 1);

    // R2 mismatch and zero dimensions while done
    bad_start(2, 2, 3, 4, "R2 inner mismatch");
    bad_start(0, 2, 3, 3, "R2 zero rows");
    bad_start(2, 0, 3, 3, "R2 zero cols");
    bad_start(2, 2, 0, 0, "R2 zero inner");

    // R8 descriptor pulse during a run is ignored
    run_case(3, 4, 5, 10, 7, 100, 6, 1'b1);

    // R5 overflow wrap: 4 * (-32768)^2 = 2^32 -> 0
    for (int x = 0; x < 4; x++) begin
      mem_a[600 + x] = 16'sh8000;
      mem_b[700 + x] = 16'sh8000;
    end
    run_case(1, 1, 4, 600, 4, 700, 1, 1'b0);
    chk(mem_c[0] == 32'd0, "R5 wrap", int'(mem_c[0]), 0);

    // R1 back-to-back restart from the done state
    run_case(2, 3, 2, 30, 5, 60, 3, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule